// File: doc/BRIEF.md
# Register Operate Unit

This block carries out the combinable register instructions of a 17-bit processor. One instruction word can name several small operations. They act on one of two working registers, A or B, and on the carry and greater-than flags. The block applies those operations in a fixed order and returns three things: the updated registers and flags, and a decision on whether the next instruction is skipped.

The surrounding processor drives the instruction, both registers, both flags and the 17-bit switch value, then pulses `start`. The block samples everything on that edge. It holds `busy` for a latency that depends on the instruction, then pulses `done` for one cycle. From that point its result outputs stay stable until the next accepted start.

Bits are numbered B17 (most significant) down to B1. An instruction is in scope when B17:B13 are zero. B12:B11 select the group, B10 selects the register (1 picks A, 0 picks B), and B9:B1 carry the operation bits. The operation bits are written below as octal masks.

Top module: `rop_unit`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are low, and every result output is zero.
- R2: A `start` seen while idle is accepted. `busy` then stays high for exactly L cycles, and `done` is high for one cycle, in the cycle where `busy` falls. L is one time unit (UNIT_CYC cycles) for every instruction except the multi-bit moves.
- R3: A multi-bit move with count n takes 1 unit when n<=1, 2 units when n<=6, 3 units when n<=11, and 4 units otherwise.
- R4: A `start` seen while `busy` is high is ignored. The results and the latency remain those of the accepted instruction.
- R5: Group B12:B11=01 does single-step moves on B16:B1 only, and B17 is kept. Mask 0200 selects left (otherwise right). Mask 0100 selects a zero-fill shift, and this shift leaves carry unchanged. Otherwise mask 0040 selects a rotate. With mask 0020, the rotate runs through a 17-bit ring that holds carry above B16.
- R6: In group 01 the tests are made on the incoming register: 0002 skips if B16=0, and 0001 skips if B1=0. The order of operations is then: 0400 clears carry, the move is applied, 0010 decrements, and 0004 increments, with 17-bit wrap.
- R7: Group 00 with mask 0400 is a multi-bit move on B16:B1. The count n is B4:B1. Mask 0300 selects the kind: 00 rotates right, 01 shifts right, 10 rotates left, 11 shifts left. B17 and carry are unchanged.
- R8: In group 00, a right shift that also has mask 0020 set is arithmetic: each step copies B17 into B16. A count of zero changes nothing.
- R9: Group 10 applies these operations in this order: 0001 loads the switches, 0400 clears, 0200 complements all bits, 0010 swaps B16:B9 with B8:B1, 0004 clears B17, and 0002 complements B17. On the carry, 0100 clears it and then 0040 complements it. Mask 0020 forces a skip.
- R10: In group 11, mask 0400 gives the sense. The selected tests are: 0200 (B17 set), 0100 (register nonzero), 0040 (carry) and 0010 (greater-than). The skip is taken if any selected test equals the sense. Tests use the incoming values.
- R11: In group 11, after the tests, 0002 clears the register, then 0001 complements it. Mask 0020 clears carry and mask 0004 clears greater-than.
- R12: The register that B10 does not select is returned unchanged.
- R13: Two kinds of word change nothing and cause no skip, and both take one unit: a word with any of B17:B13 set, and a group-00 word without mask 0400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to execute `instr` |
| instr | input | 17 | Instruction word |
| a_in | input | 17 | Current A register |
| b_in | input | 17 | Current B register |
| carry_in | input | 1 | Current carry flag |
| gt_in | input | 1 | Current greater-than flag |
| switches | input | 17 | Switch register value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| a_out | output | 17 | Resulting A register |
| b_out | output | 17 | Resulting B register |
| carry_out | output | 1 | Resulting carry flag |
| gt_out | output | 1 | Resulting greater-than flag |
| skip | output | 1 | Skip the next instruction |

## Verification
A condition test and a modification of the same register can be encoded in one word. Testing for nonzero and then clearing the register is one such case. Another is a group-01 skip on B16 combined with a left shift that changes B16. Directed words build exactly these overlaps, and random words set test and modify bits together. Each result is judged against a bench model that evaluates the tests on the incoming value before it applies any modification, so an implementation that tests the modified value shows a wrong skip.

// File: rtl/rop_pkg.sv
package rop_pkg;

    localparam int DW = 17;
    localparam int MW = DW - 1;
    localparam int CW = 4;

    typedef enum logic [1:0] {
        GRP_MULTI = 2'b00,
        GRP_SHIFT = 2'b01,
        GRP_MISC  = 2'b10,
        GRP_TEST  = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        MV_NONE,
        MV_SHIFT,
        MV_ARITH,
        MV_ROT,
        MV_ROTC
    } move_e;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          c;
        logic          gt;
        logic          skip;
    } result_t;

    function automatic logic [2:0] move_units(input logic [CW-1:0] n);
        if (n <= 4'd1)       return 3'd1;
        else if (n <= 4'd6)  return 3'd2;
        else if (n <= 4'd11) return 3'd3;
        else                 return 3'd4;
    endfunction

endpackage

// File: rtl/rop_shift.sv
module rop_shift
    import rop_pkg::*;
#(
    parameter int MAG_W = MW,
    parameter int CNT_W = CW
) (
    input  logic [MAG_W-1:0] mag_i,
    input  logic             sign_i,
    input  logic             cin_i,
    input  logic             left_i,
    input  move_e            move_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [MAG_W-1:0] mag_o,
    output logic             cout_o
);

    localparam int STEPS = 1 << CNT_W;

    always_comb begin
        logic [MAG_W-1:0] m;
        logic c;
        logic nc;
        m  = mag_i;
        c  = cin_i;
        nc = 1'b0;
        for (int i = 0; i < STEPS; i++) begin
            if (i < int'(count_i)) begin
                case (move_i)
                    MV_SHIFT: m = left_i ? {m[MAG_W-2:0], 1'b0} : {1'b0, m[MAG_W-1:1]};
                    MV_ARITH: m = left_i ? {m[MAG_W-2:0], 1'b0} : {sign_i, m[MAG_W-1:1]};
                    MV_ROT:   m = left_i ? {m[MAG_W-2:0], m[MAG_W-1]} : {m[0], m[MAG_W-1:1]};
                    MV_ROTC: begin
                        if (left_i) begin
                            nc = m[MAG_W-1];
                            m  = {m[MAG_W-2:0], c};
                        end else begin
                            nc = m[0];
                            m  = {c, m[MAG_W-1:1]};
                        end
                        c = nc;
                    end
                    default: ;
                endcase
            end
        end
        mag_o  = m;
        cout_o = c;
    end

    // R8: a zero count must leave the field and carry untouched
    always_comb begin
        if (!$isunknown(count_i) && !$isunknown(mag_i) && (count_i == '0))
            assert_zero_count_R8: assert (mag_o == mag_i && cout_o == cin_i);
    end

endmodule

// File: rtl/rop_exec.sv
module rop_exec
    import rop_pkg::*;
(
    input  logic [DW-1:0] iw_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          c_i,
    input  logic          gt_i,
    input  logic [DW-1:0] sw_i,
    output result_t       res_o,
    output logic [2:0]    units_o
);

    logic          in_scope;
    grp_e          grp;
    logic          sel_a;
    logic [8:0]    op;
    logic [DW-1:0] r0;

    move_e         sh_move;
    logic [CW-1:0] sh_cnt;
    logic          sh_cin;
    logic [MW-1:0] sh_mag;
    logic          sh_cout;

    assign in_scope = (iw_i[DW-1:12] == '0);
    assign grp      = grp_e'(iw_i[11:10]);
    assign sel_a    = iw_i[9];
    assign op       = iw_i[8:0];
    assign r0       = sel_a ? a_i : b_i;

    always_comb begin
        sh_move = MV_NONE;
        sh_cnt  = '0;
        sh_cin  = c_i;
        if (in_scope && grp == GRP_MULTI && op[8]) begin
            sh_cnt = op[CW-1:0];
            case (op[7:6])
                2'b00:   sh_move = MV_ROT;
                2'b01:   sh_move = op[4] ? MV_ARITH : MV_SHIFT;
                2'b10:   sh_move = MV_ROT;
                default: sh_move = MV_SHIFT;
            endcase
        end else if (in_scope && grp == GRP_SHIFT) begin
            sh_cnt = CW'(1);
            if (op[8])
                sh_cin = 1'b0;
            if (op[6])
                sh_move = MV_SHIFT;
            else if (op[5])
                sh_move = op[4] ? MV_ROTC : MV_ROT;
        end
    end

    rop_shift #(.MAG_W(MW), .CNT_W(CW)) u_shift (
        .mag_i   (r0[MW-1:0]),
        .sign_i  (r0[DW-1]),
        .cin_i   (sh_cin),
        .left_i  (op[7]),
        .move_i  (sh_move),
        .count_i (sh_cnt),
        .mag_o   (sh_mag),
        .cout_o  (sh_cout)
    );

    always_comb begin
        logic [DW-1:0] r;
        res_o.a    = a_i;
        res_o.b    = b_i;
        res_o.c    = c_i;
        res_o.gt   = gt_i;
        res_o.skip = 1'b0;
        units_o    = 3'd1;
        r          = r0;
        if (in_scope) begin
            case (grp)
                GRP_MULTI: begin
                    if (op[8]) begin
                        r       = {r0[DW-1], sh_mag};
                        units_o = move_units(op[CW-1:0]);
                    end
                end
                GRP_SHIFT: begin
                    res_o.skip = (op[1] && !r0[MW-1]) || (op[0] && !r0[0]);
                    res_o.c    = sh_cout;
                    r          = {r0[DW-1], sh_mag};
                    if (op[3]) r = r - 1'b1;
                    if (op[2]) r = r + 1'b1;
                end
                GRP_MISC: begin
                    if (op[0]) r = sw_i;
                    if (op[8]) r = '0;
                    if (op[7]) r = ~r;
                    if (op[3]) r = {r[DW-1], r[7:0], r[15:8]};
                    if (op[2]) r[DW-1] = 1'b0;
                    if (op[1]) r[DW-1] = ~r[DW-1];
                    if (op[6]) res_o.c = 1'b0;
                    if (op[5]) res_o.c = ~res_o.c;
                    res_o.skip = op[4];
                end
                default: begin
                    res_o.skip = (op[7] && (r0[DW-1] == op[8]))
                              || (op[6] && ((r0 != '0) == op[8]))
                              || (op[5] && (c_i == op[8]))
                              || (op[3] && (gt_i == op[8]));
                    if (op[1]) r = '0;
                    if (op[0]) r = ~r;
                    if (op[4]) res_o.c  = 1'b0;
                    if (op[2]) res_o.gt = 1'b0;
                end
            endcase
        end
        if (sel_a) res_o.a = r;
        else       res_o.b = r;
    end

    // R7: multi-bit moves never alter the sign bit of the chosen register
    always_comb begin
        if (!$isunknown(iw_i) && !$isunknown(r0) && in_scope && grp == GRP_MULTI && op[8])
            assert_sign_kept_R7: assert ((sel_a ? res_o.a[DW-1] : res_o.b[DW-1]) == r0[DW-1]);
    end

    // R5: single moves without count change keep B17
    always_comb begin
        if (!$isunknown(iw_i) && !$isunknown(r0) && in_scope && grp == GRP_SHIFT && !op[3] && !op[2])
            assert_sign_kept_R5: assert ((sel_a ? res_o.a[DW-1] : res_o.b[DW-1]) == r0[DW-1]);
    end

endmodule

// File: rtl/rop_unit.sv
module rop_unit
    import rop_pkg::*;
#(
    parameter int UNIT_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [16:0]   instr,
    input  logic [16:0]   a_in,
    input  logic [16:0]   b_in,
    input  logic          carry_in,
    input  logic          gt_in,
    input  logic [16:0]   switches,
    output logic          busy,
    output logic          done,
    output logic [16:0]   a_out,
    output logic [16:0]   b_out,
    output logic          carry_out,
    output logic          gt_out,
    output logic          skip
);

    localparam int MAX_LAT = 4 * UNIT_CYC;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        result_t          res;
    } state_t;

    state_t     st_d, st_q;
    result_t    exec_res;
    logic [2:0] exec_units;

    rop_exec u_exec (
        .iw_i    (instr),
        .a_i     (a_in),
        .b_i     (b_in),
        .c_i     (carry_in),
        .gt_i    (gt_in),
        .sw_i    (switches),
        .res_o   (exec_res),
        .units_o (exec_units)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(int'(exec_units) * UNIT_CYC - 1);
            st_d.res  = exec_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign a_out     = st_q.res.a;
    assign b_out     = st_q.res.b;
    assign carry_out = st_q.res.c;
    assign gt_out    = st_q.res.gt;
    assign skip      = st_q.res.skip;

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_done_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_out) && $stable(b_out) && $stable(carry_out)
                  && $stable(gt_out) && $stable(skip)));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.cnt < CNT_W'(MAX_LAT)));

endmodule

// File: tb/rop_unit_tb.sv
module rop_unit_tb;

    localparam int UNIT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [16:0] instr = '0, a_in = '0, b_in = '0, switches = '0;
    logic        carry_in = 1'b0, gt_in = 1'b0;
    logic        busy, done, carry_out, gt_out, skip;
    logic [16:0] a_out, b_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rop_unit #(.UNIT_CYC(UNIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .a_in(a_in), .b_in(b_in), .carry_in(carry_in), .gt_in(gt_in),
        .switches(switches), .busy(busy), .done(done), .a_out(a_out),
        .b_out(b_out), .carry_out(carry_out), .gt_out(gt_out), .skip(skip)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic [16:0] iw, a, b, input logic c, gt,
                                  input logic [16:0] sw,
                                  output logic [16:0] ea, eb, output logic ec, egt, esk,
                                  output int lat);
        logic [16:0] r;
        logic [8:0]  op;
        logic [15:0] m;
        logic [31:0] w;
        logic [16:0] ring;
        int n;
        op = iw[8:0];
        r = iw[9] ? a : b;
        ec = c; egt = gt; esk = 1'b0; lat = UNIT;
        if (iw[16:12] == 0) begin
            case (iw[11:10])
                2'd0: if (op[8]) begin
                    n = int'(op[3:0]);
                    m = r[15:0];
                    case (op[7:6])
                        2'd0: begin w = {m, m} >> n; m = w[15:0]; end
                        2'd1: begin
                            if (op[4]) begin w = {{16{r[16]}}, m} >> n; m = w[15:0]; end
                            else m = m >> n;
                        end
                        2'd2: begin w = {m, m} << n; m = w[31:16]; end
                        default: m = m << n;
                    endcase
                    r = {r[16], m};
                    lat = UNIT * ((n <= 1) ? 1 : (n <= 6) ? 2 : (n <= 11) ? 3 : 4);
                end
                2'd1: begin
                    esk = (op[1] && (r[15] == 1'b0)) || (op[0] && (r[0] == 1'b0));
                    if (op[8]) ec = 1'b0;
                    if (op[6]) begin
                        m = op[7] ? (r[15:0] << 1) : (r[15:0] >> 1);
                        r = {r[16], m};
                    end else if (op[5]) begin
                        if (op[4]) begin
                            ring = {ec, r[15:0]};
                            ring = op[7] ? {ring[15:0], ring[16]} : {ring[0], ring[16:1]};
                            ec = ring[16];
                            r = {r[16], ring[15:0]};
                        end else begin
                            w = {r[15:0], r[15:0]};
                            m = op[7] ? w[30:15] : w[16:1];
                            r = {r[16], m};
                        end
                    end
                    if (op[3]) r = r + 17'h1FFFF;
                    if (op[2]) r = r + 17'h1;
                end
                2'd2: begin
                    if (op[0]) r = sw;
                    if (op[8]) r = 0;
                    if (op[7]) r = r ^ 17'h1FFFF;
                    if (op[3]) r = {r[16], r[7:0], r[15:8]};
                    if (op[2]) r = r & 17'h0FFFF;
                    if (op[1]) r = r ^ 17'h10000;
                    if (op[6]) ec = 1'b0;
                    if (op[5]) ec = !ec;
                    esk = op[4];
                end
                default: begin
                    if (op[7] && (r[16] == op[8])) esk = 1'b1;
                    if (op[6] && ((r != 0) == op[8])) esk = 1'b1;
                    if (op[5] && (c == op[8])) esk = 1'b1;
                    if (op[3] && (gt == op[8])) esk = 1'b1;
                    if (op[1]) r = 0;
                    if (op[0]) r = r ^ 17'h1FFFF;
                    if (op[4]) ec = 1'b0;
                    if (op[2]) egt = 1'b0;
                end
            endcase
        end
        ea = iw[9] ? r : a;
        eb = iw[9] ? b : r;
    endfunction

    function automatic string tag_of(input logic [16:0] iw);
        if (iw[16:12] != 0) return "R13";
        case (iw[11:10])
            2'd0: return iw[8] ? "R7" : "R13";
            2'd1: return "R5";
            2'd2: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic drive(input logic [16:0] iw, a, b, input logic c, gt, input logic [16:0] sw);
        instr = iw; a_in = a; b_in = b; carry_in = c; gt_in = gt; switches = sw;
    endtask

    task automatic run_op(input logic [16:0] iw, a, b, input logic c, gt,
                          input logic [16:0] sw, input string tag);
        logic [16:0] ea, eb;
        logic ec, egt, esk;
        int lat, cyc;
        string ltag, otag;
        model(iw, a, b, c, gt, sw, ea, eb, ec, egt, esk, lat);
        @(negedge clk);
        drive(iw, a, b, c, gt, sw);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        drive($urandom, $urandom, $urandom, 1'b0, 1'b0, $urandom);
        cyc = 0;
        while (!done && cyc < 40) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        ltag = (iw[16:12] == 0 && iw[11:10] == 2'd0 && iw[8]) ? "R3" : "R2";
        check(cyc == lat, ltag, $sformatf("latency iw=%06o", iw), cyc, lat);
        otag = iw[9] ? "R12" : tag;
        check(a_out === ea, iw[9] ? tag : "R12", $sformatf("A iw=%06o", iw), a_out, ea);
        check(b_out === eb, otag, $sformatf("B iw=%06o", iw), b_out, eb);
        check(carry_out === ec, tag, $sformatf("carry iw=%06o", iw), carry_out, ec);
        check(gt_out === egt, tag, $sformatf("gt iw=%06o", iw), gt_out, egt);
        check(skip === esk, tag, $sformatf("skip iw=%06o", iw), skip, esk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        check(a_out == 0 && b_out == 0 && !carry_out && !gt_out && !skip, "R1",
              "outputs in reset", a_out | b_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && a_out == 0, "R1", "idle after release", {busy, done}, 0);

        // directed corner cases
        run_op(17'o005006, 17'o000000, 17'o000123, 0, 0, 0, "R9");      // clear then complement sign
        run_op(17'o007502, 17'o000005, 17'o000007, 0, 0, 0, "R10");      // test nonzero then clear
        run_op(17'o007003, 17'o012345, 17'o0, 0, 1, 0, "R11");           // clear then complement
        run_op(17'o006024, 17'o0, 17'o000444, 1, 1, 0, "R11");           // clear carry and gt
        run_op(17'o003060, 17'o100001, 17'o0, 0, 0, 0, "R5");            // rotate right through carry
        run_op(17'o003260, 17'o300000, 17'o0, 1, 0, 0, "R5");            // rotate left through carry
        run_op(17'o003300, 17'o377777, 17'o0, 1, 0, 0, "R5");            // zero-fill left shift
        run_op(17'o003660, 17'o100000, 17'o0, 1, 0, 0, "R6");            // carry cleared before rotate
        run_op(17'o003302, 17'o140000, 17'o0, 0, 0, 0, "R6");            // skip tests incoming B16
        run_op(17'o003014, 17'o377777, 17'o0, 0, 0, 0, "R6");            // decrement then increment
        run_op(17'o003004, 17'o377777, 17'o0, 0, 0, 0, "R6");            // increment wraps
        run_op(17'o001537, 17'o300000, 17'o0, 0, 0, 0, "R8");            // arithmetic right n=15
        run_op(17'o001527, 17'o040000, 17'o0, 0, 0, 0, "R8");            // arithmetic right positive
        run_op(17'o001700, 17'o123456, 17'o0, 1, 0, 0, "R8");            // zero count
        for (int n = 0; n < 16; n++)
            run_op(17'o001700 + 17'(n), 17'o052525, 17'o0, 0, 0, 0, "R3");
        run_op(17'o000407, 17'o0, 17'o100003, 0, 0, 0, "R7");            // B rotate right
        run_op(17'o001605, 17'o170001, 17'o0, 0, 0, 0, "R7");            // A rotate left
        run_op(17'o005010, 17'o112345, 17'o0, 0, 0, 0, "R9");            // byte swap
        run_op(17'o004041, 17'o0, 17'o0, 0, 0, 17'o155555, "R9");        // switches and carry flip
        run_op(17'o004020, 17'o0, 17'o0, 0, 0, 0, "R9");                 // forced skip
        run_op(17'o006440, 17'o0, 17'o0, 1, 0, 0, "R10");
        run_op(17'o006040, 17'o0, 17'o0, 1, 0, 0, "R10");
        run_op(17'o007200, 17'o200000, 17'o0, 0, 0, 0, "R10");
        run_op(17'o006410, 17'o0, 17'o0, 0, 1, 0, "R10");
        run_op(17'o002001, 17'o111111, 17'o000002, 0, 0, 0, "R12");
        run_op(17'o010000, 17'o777, 17'o666, 1, 1, 0, "R13");
        run_op(17'o000005, 17'o777, 17'o666, 1, 1, 0, "R13");

        // R4: a start while busy is ignored
        begin
            logic [16:0] ea, eb;
            logic ec, egt, esk;
            int lat, cyc;
            model(17'o001717, 17'o000001, 17'o0, 0, 0, 0, ea, eb, ec, egt, esk, lat);
            @(negedge clk);
            drive(17'o001717, 17'o000001, 17'o0, 0, 0, 0);
            start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            drive(17'o007002, 17'o077777, 17'o0, 1, 1, 0);
            cyc = 0;
            @(posedge clk);
            @(negedge clk);
            cyc++;
            start = 1'b0;
            while (!done && cyc < 40) begin
                @(posedge clk);
                @(negedge clk);
                cyc++;
            end
            check(cyc == lat, "R4", "latency kept", cyc, lat);
            check(a_out === ea && carry_out === ec && skip === esk, "R4", "result kept",
                  a_out, ea);
            @(negedge clk);
            check(!busy, "R4", "no second run", busy, 0);
        end

        // constrained random
        for (int k = 0; k < 300; k++) begin
            logic [16:0] iw;
            iw = '0;
            iw[11:10] = 2'($urandom_range(0, 3));
            iw[9]     = 1'($urandom);
            iw[8:0]   = 9'($urandom);
            if (iw[11:10] == 2'd0 && $urandom_range(0, 3) != 0) iw[8] = 1'b1;
            if ($urandom_range(0, 19) == 0) iw[16:12] = 5'($urandom_range(1, 31));
            run_op(iw, 17'($urandom), 17'($urandom), 1'($urandom), 1'($urandom),
                   17'($urandom), tag_of(iw));
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule